// File: doc/BRIEF.md
# Boot Protocol Autodetect BIOS Decoder

This block watches completed host memory cycles and decides whether each one targets the BIOS window at the top of the 4 GB space. Cycles arrive on two parallel strobe sets. One carries plain LPC memory cycles with a 32-bit address. The other carries firmware-hub cycles with a 28-bit address and a 4-bit ID field. A 3-bit size code sets the window to 256 KB shifted left by the code, so the window runs from 256 KB up to 32 MB and always ends at FFFF_FFFFh.

The block holds two protocol-enable bits, one for LPC and one for firmware-hub. After reset it does not know which protocol the host boots with. The first completed BIOS read that it answers fixes the choice: the enable bit of the other protocol is cleared. After that, only software pulses can change the bits, for example to turn the cleared protocol back on.

For each strobe cycle the block registers a hit flag and a 28-bit downstream address, one clock later. The interface carries no stream data, so every pin is a plain control or status pin with no back-pressure. The reset is synchronous, and the BIOS-enable configuration input is sampled while reset is held.

Top module: `bios_proto_decoder`

## Requirements
- R1: While rst_n is low with cfg_bios_en=1, both lpc_en and fwh_en become 1 and learning is re-armed.
- R2: While rst_n is low with cfg_bios_en=0, both enable bits become 0, and no cycle produces a hit until software sets a bit.
- R3: If the first learning read is an LPC read, fwh_en is 0 from the next clock.
- R4: If the first learning read is a firmware-hub read, lpc_en is 0 from the next clock.
- R5: Once a learning read has occurred, no later LPC or firmware-hub cycle changes either enable bit.
- R6: A pulse on sw_set_lpc sets lpc_en to 1 and a pulse on sw_set_fwh sets fwh_en to 1 at the next clock. A software set wins over a clear from learning in the same clock.
- R7: An LPC strobe hits when lpc_en=1 and lpc_addr >= 2^32 - (2^18 << cfg_size). The size code takes the values 0..7, meaning 256 KB to 32 MB. The hit shows on `hit` one clock after the strobe.
- R8: A firmware-hub strobe hits when fwh_en=1, fwh_id equals the parameter FWH_ID (default 0), and fwh_addr bits 27 down to 18+cfg_size are all ones. This is the same as {4'hF, fwh_addr} lying inside the window.
- R9: On a hit, dn_addr carries the 28 low address bits of the hitting cycle, one clock after the strobe. If both strobes hit in the same clock, the firmware-hub address is used.
- R10: Writes, aborted reads, reads outside the window and reads on a disabled protocol do not cause learning.
- R11: If a qualifying LPC read and a qualifying firmware-hub read complete in the same clock as the first learning event, the firmware-hub read wins and lpc_en is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bios_en | input | 1 | BIOS enable setting, sampled during reset |
| cfg_size | input | 3 | Window size code, 256 KB << code |
| lpc_valid | input | 1 | LPC memory cycle completes this clock |
| lpc_write | input | 1 | LPC cycle is a write |
| lpc_abort | input | 1 | LPC cycle ended in abort |
| lpc_addr | input | 32 | LPC cycle address |
| fwh_valid | input | 1 | Firmware-hub cycle completes this clock |
| fwh_write | input | 1 | Firmware-hub cycle is a write |
| fwh_abort | input | 1 | Firmware-hub cycle ended in abort |
| fwh_addr | input | 28 | Firmware-hub cycle address |
| fwh_id | input | 4 | Firmware-hub ID field |
| sw_set_lpc | input | 1 | Software pulse that sets lpc_en |
| sw_set_fwh | input | 1 | Software pulse that sets fwh_en |
| hit | output | 1 | Registered BIOS hit |
| dn_addr | output | 28 | Registered downstream address |
| lpc_en | output | 1 | LPC protocol enable |
| fwh_en | output | 1 | Firmware-hub protocol enable |

## Verification
The assertions assume that each valid strobe lasts one clock per completed cycle, and that the write and abort qualifiers are meaningful only while their valid is high. They also assume that cfg_size is held steady during a cycle. The bench drives every strobe for exactly one clock, changes the size code only between cycles, and keeps the qualifiers low whenever it has no reason to use them. With that stimulus, the learning and stickiness properties only see legal single-clock completions.

// File: rtl/bios_dec_pkg.sv
package bios_dec_pkg;
  typedef enum logic {
    ST_LEARN  = 1'b0,
    ST_LOCKED = 1'b1
  } learn_state_e;
endpackage

// File: rtl/bios_window_match.sv
module bios_window_match #(
  parameter int ADDR_W   = 32,
  parameter int IN_W     = 32,
  parameter int MIN_LOG2 = 18,
  parameter int SIZE_W   = 3
) (
  input  logic [IN_W-1:0]   addr,
  input  logic [SIZE_W-1:0] size_sel,
  output logic              match
);
  localparam int NBITS = ADDR_W - MIN_LOG2;

  logic [NBITS-1:0] bit_ok;

  // Each upper bit must be one unless it sits below the window boundary.
  for (genvar i = MIN_LOG2; i < ADDR_W; i++) begin : g_bit
    if (i < IN_W) begin : g_real
      assign bit_ok[i-MIN_LOG2] = addr[i] | (i < MIN_LOG2 + int'(size_sel));
    end else begin : g_implied
      assign bit_ok[i-MIN_LOG2] = 1'b1;
    end
  end

  assign match = &bit_ok;
endmodule

// File: rtl/bios_learn_fsm.sv
module bios_learn_fsm
  import bios_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_bios_en,
  input  logic lpc_rd_seen,
  input  logic fwh_rd_seen,
  input  logic sw_set_lpc,
  input  logic sw_set_fwh,
  output logic lpc_en,
  output logic fwh_en
);
  learn_state_e state_q;
  logic         learn_now;
  logic         clr_lpc, clr_fwh;

  assign learn_now = (state_q == ST_LEARN) && (lpc_rd_seen || fwh_rd_seen);
  // Firmware-hub takes priority when both complete together.
  assign clr_lpc   = learn_now && fwh_rd_seen;
  assign clr_fwh   = learn_now && !fwh_rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LEARN;
      lpc_en  <= cfg_bios_en;
      fwh_en  <= cfg_bios_en;
    end else begin
      if (learn_now) state_q <= ST_LOCKED;
      if (sw_set_lpc)   lpc_en <= 1'b1;
      else if (clr_lpc) lpc_en <= 1'b0;
      if (sw_set_fwh)   fwh_en <= 1'b1;
      else if (clr_fwh) fwh_en <= 1'b0;
    end
  end

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED));

  assert_bits_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && !sw_set_lpc && !sw_set_fwh) |=> ($stable(lpc_en) && $stable(fwh_en)));

  assert_fwh_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEARN && fwh_rd_seen && !sw_set_lpc) |=> !lpc_en);

  assert_lpc_learn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEARN && lpc_rd_seen && !fwh_rd_seen && !sw_set_fwh) |=> !fwh_en);

  assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set_lpc || sw_set_fwh) |=> ((lpc_en || !$past(sw_set_lpc)) && (fwh_en || !$past(sw_set_fwh))));
endmodule

// File: rtl/bios_proto_decoder.sv
module bios_proto_decoder #(
  parameter int         ADDR_W   = 32,
  parameter int         DN_W     = 28,
  parameter int         MIN_LOG2 = 18,
  parameter int         SIZE_W   = 3,
  parameter int         ID_W     = 4,
  parameter logic [3:0] FWH_ID   = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bios_en,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              lpc_valid,
  input  logic              lpc_write,
  input  logic              lpc_abort,
  input  logic [ADDR_W-1:0] lpc_addr,
  input  logic              fwh_valid,
  input  logic              fwh_write,
  input  logic              fwh_abort,
  input  logic [DN_W-1:0]   fwh_addr,
  input  logic [ID_W-1:0]   fwh_id,
  input  logic              sw_set_lpc,
  input  logic              sw_set_fwh,
  output logic              hit,
  output logic [DN_W-1:0]   dn_addr,
  output logic              lpc_en,
  output logic              fwh_en
);
  logic lpc_in_win, fwh_in_win;
  logic lpc_hit, fwh_hit;
  logic lpc_rd_seen, fwh_rd_seen;

  bios_window_match #(.ADDR_W(ADDR_W), .IN_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SIZE_W(SIZE_W))
    u_lpc_win (.addr(lpc_addr), .size_sel(cfg_size), .match(lpc_in_win));

  bios_window_match #(.ADDR_W(ADDR_W), .IN_W(DN_W), .MIN_LOG2(MIN_LOG2), .SIZE_W(SIZE_W))
    u_fwh_win (.addr(fwh_addr), .size_sel(cfg_size), .match(fwh_in_win));

  assign lpc_hit = lpc_valid && lpc_en && lpc_in_win;
  assign fwh_hit = fwh_valid && fwh_en && fwh_in_win && (fwh_id == ID_W'(FWH_ID));

  assign lpc_rd_seen = lpc_hit && !lpc_write && !lpc_abort;
  assign fwh_rd_seen = fwh_hit && !fwh_write && !fwh_abort;

  bios_learn_fsm u_learn (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bios_en(cfg_bios_en),
    .lpc_rd_seen(lpc_rd_seen),
    .fwh_rd_seen(fwh_rd_seen),
    .sw_set_lpc (sw_set_lpc),
    .sw_set_fwh (sw_set_fwh),
    .lpc_en     (lpc_en),
    .fwh_en     (fwh_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      dn_addr <= '0;
    end else begin
      hit <= lpc_hit || fwh_hit;
      if (fwh_hit)      dn_addr <= fwh_addr;
      else if (lpc_hit) dn_addr <= lpc_addr[DN_W-1:0];
    end
  end

  assert_hit_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(lpc_valid || fwh_valid));

  assert_hit_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lpc_en && !fwh_en && !sw_set_lpc && !sw_set_fwh) |=> !hit);

  assert_fwh_addr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwh_hit |=> (hit && dn_addr == $past(fwh_addr)));
endmodule

// File: tb/bios_proto_decoder_tb.sv
module bios_proto_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_bios_en;
  logic [2:0]  cfg_size;
  logic        lpc_valid, lpc_write, lpc_abort;
  logic [31:0] lpc_addr;
  logic        fwh_valid, fwh_write, fwh_abort;
  logic [27:0] fwh_addr;
  logic [3:0]  fwh_id;
  logic        sw_set_lpc, sw_set_fwh;
  logic        hit;
  logic [27:0] dn_addr;
  logic        lpc_en, fwh_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  bios_proto_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bios_en(cfg_bios_en), .cfg_size(cfg_size),
    .lpc_valid(lpc_valid), .lpc_write(lpc_write), .lpc_abort(lpc_abort), .lpc_addr(lpc_addr),
    .fwh_valid(fwh_valid), .fwh_write(fwh_write), .fwh_abort(fwh_abort), .fwh_addr(fwh_addr),
    .fwh_id(fwh_id), .sw_set_lpc(sw_set_lpc), .sw_set_fwh(sw_set_fwh),
    .hit(hit), .dn_addr(dn_addr), .lpc_en(lpc_en), .fwh_en(fwh_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lpc_valid = 0; lpc_write = 0; lpc_abort = 0; lpc_addr = '0;
    fwh_valid = 0; fwh_write = 0; fwh_abort = 0; fwh_addr = '0; fwh_id = '0;
    sw_set_lpc = 0; sw_set_fwh = 0;
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    idle_inputs();
    cfg_bios_en = en;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // Present one cycle at a negedge, sample the registered result just after the next posedge.
  task automatic lpc_cycle(input logic [31:0] a, input logic wr, input logic ab);
    @(negedge clk);
    idle_inputs();
    lpc_valid = 1; lpc_addr = a; lpc_write = wr; lpc_abort = ab;
    @(posedge clk); #1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic fwh_cycle(input logic [27:0] a, input logic [3:0] id, input logic wr);
    @(negedge clk);
    idle_inputs();
    fwh_valid = 1; fwh_addr = a; fwh_id = id; fwh_write = wr;
    @(posedge clk); #1;
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic logic [31:0] win_lo(input int s);
    return 32'hFFFF_FFFF - ((32'h0004_0000 << s) - 1);
  endfunction

  logic hit_s;
  logic [27:0] dn_s;

  // Variants that capture outputs right after the active edge.
  task automatic lpc_probe(input logic [31:0] a, input logic wr, input logic ab);
    @(negedge clk);
    idle_inputs();
    lpc_valid = 1; lpc_addr = a; lpc_write = wr; lpc_abort = ab;
    @(posedge clk); #1;
    hit_s = hit; dn_s = dn_addr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic fwh_probe(input logic [27:0] a, input logic [3:0] id, input logic wr);
    @(negedge clk);
    idle_inputs();
    fwh_valid = 1; fwh_addr = a; fwh_id = id; fwh_write = wr;
    @(posedge clk); #1;
    hit_s = hit; dn_s = dn_addr;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #3_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle_inputs();
    cfg_size = 3'd0;
    do_reset(1'b1);
    chk("R1 reset lpc_en", {31'd0, lpc_en}, 32'd1);
    chk("R1 reset fwh_en", {31'd0, fwh_en}, 32'd1);
    chk("R1 reset hit", {31'd0, hit}, 32'd0);

    // Window sweep with writes only, so nothing is learned (R7, R8, R9, R10).
    for (int s = 0; s < 8; s++) begin
      logic [31:0] lo;
      logic [31:0] la [5];
      logic [27:0] fa [3];
      cfg_size = 3'(s);
      lo = win_lo(s);
      la[0] = lo; la[1] = lo - 1; la[2] = 32'hFFFF_FFFF; la[3] = lo + 32'h123; la[4] = 32'h0000_0000;
      fa[0] = lo[27:0]; fa[1] = lo[27:0] - 1; fa[2] = 28'hFFF_FFFF;
      for (int k = 0; k < 5; k++) begin
        logic e;
        e = (la[k] >= lo);
        lpc_probe(la[k], 1'b1, 1'b0);
        chk("R7 lpc window hit", {31'd0, hit_s}, {31'd0, e});
        if (e) chk("R9 lpc dn_addr", {4'd0, dn_s}, {4'd0, la[k][27:0]});
      end
      for (int id = 0; id < 2; id++) begin
        for (int k = 0; k < 3; k++) begin
          logic e;
          e = (id == 0) && ({4'hF, fa[k]} >= lo);
          fwh_probe(fa[k], 4'(id), 1'b1);
          chk("R8 fwh window hit", {31'd0, hit_s}, {31'd0, e});
          if (e) chk("R9 fwh dn_addr", {4'd0, dn_s}, {4'd0, fa[k]});
        end
      end
    end
    chk("R10 writes leave lpc_en", {31'd0, lpc_en}, 32'd1);
    chk("R10 writes leave fwh_en", {31'd0, fwh_en}, 32'd1);

    cfg_size = 3'd2;
    lpc_cycle(32'hFFFF_F000, 1'b0, 1'b1);
    chk("R10 aborted read lpc_en", {31'd0, lpc_en}, 32'd1);
    chk("R10 aborted read fwh_en", {31'd0, fwh_en}, 32'd1);
    lpc_cycle(32'h1000_0000, 1'b0, 1'b0);
    fwh_cycle(28'hFFF_F000, 4'h3, 1'b0);
    chk("R10 outside read lpc_en", {31'd0, lpc_en}, 32'd1);
    chk("R10 outside read fwh_en", {31'd0, fwh_en}, 32'd1);

    // Simultaneous first reads: firmware-hub wins (R11).
    @(negedge clk);
    idle_inputs();
    lpc_valid = 1; lpc_addr = 32'hFFFF_0010;
    fwh_valid = 1; fwh_addr = 28'hFFF_0020; fwh_id = 4'h0;
    @(posedge clk); #1;
    chk("R9 both hit", {31'd0, hit}, 32'd1);
    chk("R9 fwh address wins", {4'd0, dn_addr}, 32'h0FFF_0020);
    chk("R11 lpc_en cleared", {31'd0, lpc_en}, 32'd0);
    chk("R11 fwh_en kept", {31'd0, fwh_en}, 32'd1);
    @(negedge clk);
    idle_inputs();

    lpc_probe(32'hFFFF_0010, 1'b0, 1'b0);
    chk("R4 lpc ignored after fwh learn", {31'd0, hit_s}, 32'd0);
    fwh_probe(28'hFFF_0040, 4'h0, 1'b0);
    chk("R5 fwh still answered", {31'd0, hit_s}, 32'd1);
    chk("R5 lpc_en stays 0", {31'd0, lpc_en}, 32'd0);
    chk("R5 fwh_en stays 1", {31'd0, fwh_en}, 32'd1);

    @(negedge clk);
    sw_set_lpc = 1;
    @(negedge clk);
    sw_set_lpc = 0;
    chk("R6 software restores lpc_en", {31'd0, lpc_en}, 32'd1);
    lpc_probe(32'hFFFF_0080, 1'b0, 1'b0);
    chk("R6 lpc answered again", {31'd0, hit_s}, 32'd1);
    chk("R5 no relearn fwh_en", {31'd0, fwh_en}, 32'd1);
    chk("R5 no relearn lpc_en", {31'd0, lpc_en}, 32'd1);

    // Fresh reset, LPC read first (R3).
    do_reset(1'b1);
    lpc_cycle(32'hFFFF_FF00, 1'b0, 1'b0);
    chk("R3 fwh_en cleared", {31'd0, fwh_en}, 32'd0);
    chk("R3 lpc_en kept", {31'd0, lpc_en}, 32'd1);
    fwh_probe(28'hFFF_FF00, 4'h0, 1'b0);
    chk("R3 fwh ignored", {31'd0, hit_s}, 32'd0);
    fwh_cycle(28'hFFF_FF00, 4'h0, 1'b0);
    chk("R5 lpc_en unchanged", {31'd0, lpc_en}, 32'd1);

    // Fresh reset, single firmware-hub read first (R4).
    do_reset(1'b1);
    fwh_cycle(28'hFFF_FF00, 4'h0, 1'b0);
    chk("R4 lpc_en cleared", {31'd0, lpc_en}, 32'd0);
    chk("R4 fwh_en kept", {31'd0, fwh_en}, 32'd1);

    // Learning clear and software set in the same clock (R6).
    do_reset(1'b1);
    @(negedge clk);
    idle_inputs();
    lpc_valid = 1; lpc_addr = 32'hFFFF_FF00; sw_set_fwh = 1;
    @(negedge clk);
    idle_inputs();
    chk("R6 set beats learn clear", {31'd0, fwh_en}, 32'd1);
    lpc_cycle(32'hFFFF_FF00, 1'b0, 1'b0);
    chk("R6 then locked fwh_en", {31'd0, fwh_en}, 32'd1);

    // Disabled at reset (R2).
    do_reset(1'b0);
    chk("R2 lpc_en zero", {31'd0, lpc_en}, 32'd0);
    chk("R2 fwh_en zero", {31'd0, fwh_en}, 32'd0);
    lpc_probe(32'hFFFF_FFF0, 1'b0, 1'b0);
    chk("R2 lpc no hit", {31'd0, hit_s}, 32'd0);
    fwh_probe(28'hFFF_FFF0, 4'h0, 1'b0);
    chk("R2 fwh no hit", {31'd0, hit_s}, 32'd0);
    @(negedge clk);
    sw_set_fwh = 1;
    @(negedge clk);
    sw_set_fwh = 0;
    lpc_cycle(32'hFFFF_FFF0, 1'b0, 1'b0);
    chk("R10 disabled lpc read no learn", {31'd0, fwh_en}, 32'd1);
    fwh_probe(28'hFFF_FFF0, 4'h0, 1'b0);
    chk("R2 fwh answered after set", {31'd0, hit_s}, 32'd1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule